// File: doc/BRIEF.md
# Bus-Controlled Four-Channel SAR Conversion Sequencer

This block is the digital controller of a four-channel successive-approximation converter that sits on a host's byte-wide bus. The host pulls chip select low and pulses the write strobe. On the rising edge of that strobe the block latches a 2-bit channel number and starts a conversion of fixed length. The conversion has an acquisition window, during which the analog side samples the input and zeroes the comparator. After that, 12 trial steps run, starting with the most significant bit, and each step uses a single comparator bit that the analog side feeds back.

The busy output stays low from the cycle after the start edge until the result register holds the new code. The host then collects the 12-bit straight-binary result as two bytes over a shared three-state bus, and a byte-select input picks the low or the high byte. The multiplexer, the capacitor network and the comparator are outside the block. The block only provides the channel select, a sampling flag and the trial code that the analog side compares against.

Top module: `sarSequencer`

## Requirements
- R1: With the block idle, the first clock edge that sees wrN high after it was low, with csN low, starts a conversion, and busyN is low after that edge. busyN is high after reset.
- R2: The channel number on chanAddr is captured on the start edge. chanSel holds that value for the whole conversion, even if chanAddr changes.
- R3: sampleEn is high for exactly SAMPLE_CYCLES (5) cycles right after the start, and trialCode is zero during that time.
- R4: In the first trial cycle, trialCode is 0x800 (only bit 11 set). At the end of each trial cycle the current trial bit is kept if compIn is high (input at or above the trial code) and cleared otherwise. The next lower bit is then set, working down to bit 0.
- R5: busyN stays low for exactly 17 cycles (5 sample plus 12 trial). It rises only on the edge that stores the finished result.
- R6: The result is straight binary. It is the largest code whose trial compIn accepted: an input at or below zero gives 0x000, and an input at or above full scale gives 0xFFF.
- R7: With hiByteSel low, a read returns result bits 7:0. With hiByteSel high, a read returns result bits 11:8 in data bits 3:0, and data bits 7:4 read as zero.
- R8: dataBus is driven only while csN and rdN are both low. Otherwise it is high-impedance.
- R9: A write edge that arrives while busyN is low is ignored. The running conversion keeps its channel and its timing.
- R10: The result register changes only when a conversion completes. A read during a conversion returns the previous result, and after reset it reads 0x000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select |
| wrN | input | 1 | Active-low write strobe; its rising edge starts a conversion |
| rdN | input | 1 | Active-low read strobe |
| hiByteSel | input | 1 | Selects the high (1) or low (0) result byte |
| chanAddr | input | 2 | Channel number, captured at start |
| compIn | input | 1 | Comparator decision: 1 when the input is at or above trialCode |
| chanSel | output | 2 | Latched channel that drives the analog multiplexer |
| sampleEn | output | 1 | High during the acquisition and auto-zero window |
| trialCode | output | 12 | Code currently under trial by the comparator |
| busyN | output | 1 | Low while a conversion is in progress |
| dataBus | inout | 8 | Three-state read data bus |

## Verification
The bench builds the block with its default parameters: 12 result bits, an 8-bit bus, 2 channel bits and a 5-cycle sample window. These values fix the frame at exactly 17 busy cycles, so the behavioural model can predict every cycle of busyN, sampleEn and the first trial code. A comparator model that holds one analog level per channel reaches both ends of the scale and mid-scale codes, and a level beyond full scale checks clipping to 0xFFF. The split between the nibble and the byte is reached as well, as are reads taken in the middle of a conversion and write edges that arrive while a conversion runs.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  // Strobes from the sequencing control to the datapath
  typedef struct packed {
    logic loadChan;   // capture channel, clear trial state
    logic startSar;   // last sample cycle: seed MSB trial
    logic sarStep;    // a trial cycle: resolve current bit
    logic lastStep;   // final trial cycle: store result
  } seqStrobe_t;
endpackage

// File: rtl/sarSeqCtrl.sv
module sarSeqCtrl
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS      = 12,
  parameter int SAMPLE_CYCLES = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       wrN,
  output seqStrobe_t strb,
  output logic       busyN,
  output logic       sampleEn
);
  localparam int MAX_CNT = (RES_BITS > SAMPLE_CYCLES) ? RES_BITS : SAMPLE_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SAMPLE, ST_SAR} seqState_t;

  seqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic             wrPrevN;
  logic             wrRise;

  assign wrRise = wrN & ~wrPrevN;

  always_comb begin
    strb.loadChan = (state == ST_IDLE) && wrRise && !csN;
    strb.startSar = (state == ST_SAMPLE) && (cnt == CNT_W'(SAMPLE_CYCLES - 1));
    strb.sarStep  = (state == ST_SAR);
    strb.lastStep = (state == ST_SAR) && (cnt == CNT_W'(RES_BITS - 1));
  end

  assign busyN    = (state == ST_IDLE);
  assign sampleEn = (state == ST_SAMPLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      wrPrevN <= 1'b1;
    end else begin
      wrPrevN <= wrN;
      unique case (state)
        ST_IDLE: if (strb.loadChan) begin
          state <= ST_SAMPLE;
          cnt   <= '0;
        end
        ST_SAMPLE: if (strb.startSar) begin
          state <= ST_SAR;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        ST_SAR: if (strb.lastStep) begin
          state <= ST_IDLE;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadChan |=> !busyN);

  // R5
  busy_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyN) |-> $past(strb.lastStep));

  // R3
  sample_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleEn |-> (cnt < CNT_W'(SAMPLE_CYCLES)));

  // R9
  wr_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busyN && !strb.lastStep) |=> !busyN);
endmodule

// File: rtl/sarSeqPath.sv
module sarSeqPath
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS  = 12,
  parameter int BUS_BITS  = 8,
  parameter int CHAN_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobe_t           strb,
  input  logic [CHAN_BITS-1:0] chanAddr,
  input  logic                 compIn,
  input  logic                 csN,
  input  logic                 rdN,
  input  logic                 hiByteSel,
  output logic [CHAN_BITS-1:0] chanSel,
  output logic [RES_BITS-1:0]  trialCode,
  inout  wire  [BUS_BITS-1:0]  dataBus
);
  localparam logic [RES_BITS-1:0] MSB_MASK = {1'b1, {(RES_BITS-1){1'b0}}};

  logic [RES_BITS-1:0] bitMark;
  logic [RES_BITS-1:0] keepCode;
  logic [RES_BITS-1:0] result;
  logic [BUS_BITS-1:0] readByte;
  logic                readEn;

  // Keep the trial bit when the input reaches the trial code
  assign keepCode = compIn ? trialCode : (trialCode & ~bitMark);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanSel   <= '0;
      trialCode <= '0;
      bitMark   <= '0;
      result    <= '0;
    end else begin
      if (strb.loadChan) begin
        chanSel   <= chanAddr;
        trialCode <= '0;
        bitMark   <= '0;
      end
      if (strb.startSar) begin
        trialCode <= MSB_MASK;
        bitMark   <= MSB_MASK;
      end
      if (strb.sarStep) begin
        bitMark <= bitMark >> 1;
        if (strb.lastStep) begin
          result    <= keepCode;
          trialCode <= '0;
        end else begin
          trialCode <= keepCode | (bitMark >> 1);
        end
      end
    end
  end

  generate
    if (RES_BITS > BUS_BITS) begin : g_twoByte
      assign readByte = hiByteSel ? BUS_BITS'(result[RES_BITS-1:BUS_BITS])
                                  : result[BUS_BITS-1:0];
    end else begin : g_oneByte
      assign readByte = hiByteSel ? '0 : BUS_BITS'(result);
    end
  endgenerate

  assign readEn  = !csN && !rdN;
  assign dataBus = readEn ? readByte : 'z;

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.lastStep |=> $stable(result));

  // R4
  first_trial_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.startSar |=> ($countones(trialCode) == 1) && trialCode[RES_BITS-1]);

  // R2
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadChan |=> $stable(chanSel));
endmodule

// File: rtl/sarSequencer.sv
module sarSequencer
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS      = 12,
  parameter int BUS_BITS      = 8,
  parameter int CHAN_BITS     = 2,
  parameter int SAMPLE_CYCLES = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csN,
  input  logic                 wrN,
  input  logic                 rdN,
  input  logic                 hiByteSel,
  input  logic [CHAN_BITS-1:0] chanAddr,
  input  logic                 compIn,
  output logic [CHAN_BITS-1:0] chanSel,
  output logic                 sampleEn,
  output logic [RES_BITS-1:0]  trialCode,
  output logic                 busyN,
  inout  wire  [BUS_BITS-1:0]  dataBus
);
  seqStrobe_t strb;

  sarSeqCtrl #(
    .RES_BITS(RES_BITS), .SAMPLE_CYCLES(SAMPLE_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN),
    .strb(strb), .busyN(busyN), .sampleEn(sampleEn)
  );

  sarSeqPath #(
    .RES_BITS(RES_BITS), .BUS_BITS(BUS_BITS), .CHAN_BITS(CHAN_BITS)
  ) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .chanAddr(chanAddr),
    .compIn(compIn), .csN(csN), .rdN(rdN), .hiByteSel(hiByteSel),
    .chanSel(chanSel), .trialCode(trialCode), .dataBus(dataBus)
  );
endmodule

// File: tb/sarSequencer_test.sv
module sarSequencer_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int  FRAME      = 17;
  localparam int  SAR_LEN    = 12;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1, wrN = 1'b1, rdN = 1'b1, hiByteSel = 1'b0;
  logic [1:0]  chanAddr = 2'd0;
  logic        compIn;
  logic [1:0]  chanSel;
  logic        sampleEn;
  logic [11:0] trialCode;
  logic        busyN;
  wire  [7:0]  dataBus;

  int vin [4];
  int checks = 0, fails = 0;
  bit finished = 0;

  // Reference model state
  int remain = 0;
  int latCh = 0;
  int expResult = 0;
  logic wrPrev = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Comparator model: high when the selected level reaches the trial code
  assign compIn = (vin[chanSel] >= int'(trialCode));

  sarSequencer uut (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN), .rdN(rdN),
    .hiByteSel(hiByteSel), .chanAddr(chanAddr), .compIn(compIn),
    .chanSel(chanSel), .sampleEn(sampleEn), .trialCode(trialCode),
    .busyN(busyN), .dataBus(dataBus)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int clip(input int v);
    return (v < 0) ? 0 : ((v > 4095) ? 4095 : v);
  endfunction

  // Behavioural cycle model
  always @(posedge clk) begin
    if (!rstN) begin
      remain = 0; expResult = 0; wrPrev = 1'b1;
    end else begin
      int prevRem;
      prevRem = remain;
      if (remain > 0) remain--;
      if (prevRem == 1) expResult = clip(vin[latCh]);
      if (prevRem == 0 && wrN && !wrPrev && !csN) begin
        remain = FRAME;
        latCh  = chanAddr;
      end
      wrPrev = wrN;
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk(busyN == (remain == 0), "R5 busy", busyN, remain == 0);
      chk(sampleEn == (remain > SAR_LEN), "R3 sample window", sampleEn, remain > SAR_LEN);
      if (remain > SAR_LEN)
        chk(trialCode == 12'h000, "R3 trial idle while sampling", trialCode, 0);
      if (remain > 0)
        chk(chanSel == latCh[1:0], "R2 channel latched", chanSel, latCh);
      if (remain == SAR_LEN)
        chk(trialCode == 12'h800, "R4 first trial", trialCode, 12'h800);
    end
  end

  task automatic startConv(input int ch);
    @(negedge clk); csN = 1'b0; wrN = 1'b0; chanAddr = ch[1:0];
    @(negedge clk); wrN = 1'b1;
    @(negedge clk); csN = 1'b1;
  endtask

  task automatic waitDone();
    @(negedge clk);
    while (remain != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic readByte(input bit hi, input int exp, input string tag);
    @(negedge clk); csN = 1'b0; rdN = 1'b0; hiByteSel = hi;
    #1;
    chk(dataBus === exp[7:0], tag, dataBus, exp[7:0]);
    @(negedge clk); csN = 1'b1; rdN = 1'b1;
  endtask

  task automatic readBoth(input string tag);
    readByte(1'b0, expResult & 8'hFF, {tag, " R7 low byte"});
    readByte(1'b1, (expResult >> 8) & 8'h0F, {tag, " R7 high byte"});
  endtask

  initial begin
    vin[0] = 0; vin[1] = 12'h123; vin[2] = 12'hA5C; vin[3] = 5000;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(busyN === 1'b1, "R1 busy idle after reset", busyN, 1);
    readByte(1'b0, 0, "R10 reset low byte");
    readByte(1'b1, 0, "R10 reset high byte");

    // R8: bus floats without chip select, or without read
    @(negedge clk); csN = 1'b1; rdN = 1'b0; #1;
    chk(dataBus === 8'hzz, "R8 float no cs", dataBus, 0);
    @(negedge clk); csN = 1'b0; rdN = 1'b1; #1;
    chk(dataBus === 8'hzz, "R8 float no rd", dataBus, 0);
    @(negedge clk); csN = 1'b1;

    // R1 R6: mid-scale on channel 2
    startConv(2);
    chk(busyN === 1'b0, "R1 busy after start", busyN, 0);
    waitDone();
    chk(expResult == 12'hA5C, "R6 model mid", expResult, 12'hA5C);
    readBoth("R6 mid");

    // R6: zero scale, then over full scale clipping
    startConv(0); waitDone(); readBoth("R6 zero");
    startConv(3); waitDone();
    chk(expResult == 12'hFFF, "R6 model full", expResult, 12'hFFF);
    readBoth("R6 full");

    // R9 R2 R10: ignored write, address change, read mid-conversion
    startConv(1);
    repeat (3) @(negedge clk);
    chanAddr = 2'd2;
    csN = 1'b0; wrN = 1'b0;
    @(negedge clk); wrN = 1'b1;
    @(negedge clk); csN = 1'b1;
    readByte(1'b0, 8'hFF, "R10 previous low during conversion");
    readByte(1'b1, 8'h0F, "R10 previous high during conversion");
    waitDone();
    chk(expResult == 12'h123, "R9 ignored write kept channel 1", expResult, 12'h123);
    readBoth("R9 after ignored write");

    // R4: bit-boundary levels
    vin[1] = 12'h800; startConv(1); waitDone(); readBoth("R4 exact MSB");
    vin[1] = 12'h7FF; startConv(1); waitDone(); readBoth("R4 below MSB");
    vin[0] = -30;     startConv(0); waitDone(); readBoth("R6 negative");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule